// File: doc/BRIEF.md
# Signed Shift-and-Add Array Multiplier

This block forms the product of a signed sample and a signed coefficient, as needed in one tap of a finite impulse response filter. It has no clock and no internal state. For every coefficient bit it builds one 40-bit partial term. Where the bit is set, the term holds the sample shifted to that bit's weight. Where it is clear, the term is zero. A chain of full-width ripple-carry adders then sums these terms one after another.

No shifter and no shorter adder appear anywhere. The shift is made by wiring the sample into the right bit positions of a fixed 40-bit word. Positions below the sample are zero. Positions above it repeat the sample's sign bit. The term that belongs to the coefficient's sign bit has a negative weight in two's complement, so the last adder subtracts it. It does this by adding the bitwise inverse of the term with a carry-in of one. Delay and area both grow with the product of the two operand widths.

The sample and coefficient widths are parameters and default to 16 bits each. Their sum must not exceed the 40-bit product width, and elaboration stops if it does.

Top module: `sam_mult`

## Requirements
- R1: `product_o` equals the two's complement product of `data_i` and `coef_i`, sign-extended to 40 bits, for every pair of operand values.
- R2: The partial term for coefficient bit k carries the sample in bit positions k through k+DATA_W-1 when that coefficient bit is 1.
- R3: In every partial term, the bit positions below k are 0.
- R4: In a selected partial term, the bit positions above the placed sample all equal the sample's most significant bit, so a negative sample yields a negative term.
- R5: A partial term whose coefficient bit is 0 is all zeros. A single-bit coefficient 2^k therefore gives exactly data·2^k.
- R6: The partial term for the coefficient's most significant bit is subtracted: its inverse is added with a carry-in of 1. A negative coefficient therefore gives a negated weighting.
- R7: Every adder in the chain is a 40-bit ripple-carry adder whose sum, reduced modulo 2^40, equals a+b+carry-in. All 40 product bits, including those above DATA_W+COEF_W, are therefore correct.
- R8: The block is purely combinational. `product_o` follows any change of the inputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Signed sample (two's complement) |
| coef_i | input | COEF_W | Signed coefficient (two's complement) |
| product_o | output | 40 | Signed product, sign-extended to 40 bits |

## Verification
Zero operands and single-bit coefficients separate term gating and placement from the adder chain: each single-bit coefficient must give exactly the shifted sample. Minus one on either side, most-negative times most-negative and most-negative times most-positive isolate the subtraction of the sign-bit term. A wrong sign on that term shows up at once in these cases. Negative samples with large coefficients test sign filling all the way to bit 39. Random operand pairs and back-to-back input changes within one clock period cover the general product and show that the output follows the inputs with no clock edge.

// File: rtl/sam_pkg.sv
package sam_pkg;

    // Fixed width of every partial term, every adder and the product.
    localparam int ACC_W = 40;

    typedef logic [ACC_W-1:0] acc_t;

    // Operand presented to one ripple stage: addend and carry-in.
    typedef struct packed {
        acc_t addend;
        logic carry_in;
    } stage_in_t;

    // Sign-extend an operand of width w (held in the low bits) to ACC_W.
    function automatic acc_t sext(input acc_t v, input int w);
        acc_t r;
        for (int b = 0; b < ACC_W; b++) begin
            r[b] = (b < w) ? v[b] : v[w-1];
        end
        return r;
    endfunction

    // Operand for a stage: plain add, or inverted with carry-in for subtract.
    function automatic stage_in_t make_stage(input acc_t term, input logic subtract);
        stage_in_t s;
        s.addend   = subtract ? ~term : term;
        s.carry_in = subtract;
        return s;
    endfunction

endpackage

// File: rtl/sam_summand.sv
module sam_summand
    import sam_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SHIFT  = 0
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              gate_i,
    output acc_t              term_o
);

    localparam int TOP = SHIFT + DATA_W;

    // Placement by wiring: each bit of the term comes from a fixed source.
    for (genvar b = 0; b < ACC_W; b++) begin : g_bit
        if (b < SHIFT) begin : g_low
            assign term_o[b] = 1'b0;
        end else if (b < TOP) begin : g_data
            assign term_o[b] = gate_i & data_i[b-SHIFT];
        end else begin : g_fill
            assign term_o[b] = gate_i & data_i[DATA_W-1];
        end
    end

    // Arithmetic reference for the whole term: signed sample times 2^SHIFT.
    acc_t scaled_ref;
    always_comb begin
        scaled_ref = sext(acc_t'(data_i), DATA_W) << SHIFT;
    end

    always_comb begin
        if (!$isunknown({data_i, gate_i})) begin
            // R2 and R4: a selected term is the sign-extended sample at its weight
            a_r4_term_value: assert (!gate_i || term_o == scaled_ref)
                else $error("term for shift %0d wrong: %h", SHIFT, term_o);
            // R5: a deselected term contributes nothing
            a_r5_gated_zero: assert (gate_i || term_o == '0)
                else $error("gated term for shift %0d not zero", SHIFT);
        end
    end

    if (SHIFT > 0) begin : g_low_chk
        always_comb begin
            // R3: positions below the weight are zero
            a_r3_low_zero: assert ($isunknown(data_i) || term_o[SHIFT-1:0] == '0)
                else $error("low bits of term %0d not zero", SHIFT);
        end
    end

endmodule

// File: rtl/sam_rca.sv
module sam_rca
    import sam_pkg::*;
(
    input  acc_t a_i,
    input  acc_t b_i,
    input  logic cin_i,
    output acc_t sum_o
);

    // Carry into each bit position; the carry out of the top bit is not kept.
    logic [ACC_W-1:0] carry;

    assign carry[0] = cin_i;

    for (genvar b = 0; b < ACC_W; b++) begin : g_fa
        assign sum_o[b] = a_i[b] ^ b_i[b] ^ carry[b];
        if (b < ACC_W - 1) begin : g_carry
            assign carry[b+1] = (a_i[b] & b_i[b]) | (carry[b] & (a_i[b] ^ b_i[b]));
        end
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            // R7: the ripple chain produces the modulo-2^40 sum
            a_r7_ripple_sum: assert (sum_o == a_i + b_i + acc_t'(cin_i))
                else $error("ripple sum wrong: %h + %h + %b -> %h", a_i, b_i, cin_i, sum_o);
        end
    end

endmodule

// File: rtl/sam_mult.sv
module sam_mult
    import sam_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [COEF_W-1:0] coef_i,
    output logic [ACC_W-1:0]  product_o
);

    localparam int LAST = COEF_W - 1;

    if (DATA_W + COEF_W > ACC_W) begin : g_width_err
        $error("DATA_W + COEF_W exceeds the product width");
    end

    acc_t      term    [COEF_W];
    stage_in_t stage_in[COEF_W];
    acc_t      partial [COEF_W+1];

    assign partial[0] = '0;

    for (genvar k = 0; k < COEF_W; k++) begin : g_tap
        sam_summand #(
            .DATA_W(DATA_W),
            .SHIFT (k)
        ) u_summand (
            .data_i(data_i),
            .gate_i(coef_i[k]),
            .term_o(term[k])
        );

        // The sign bit of the coefficient carries weight -2^LAST.
        assign stage_in[k] = make_stage(term[k], (k == LAST));

        sam_rca u_rca (
            .a_i  (partial[k]),
            .b_i  (stage_in[k].addend),
            .cin_i(stage_in[k].carry_in),
            .sum_o(partial[k+1])
        );
    end

    assign product_o = partial[COEF_W];

    // Reference product from the built-in signed multiply.
    acc_t data_ext, coef_ext, product_ref;
    always_comb begin
        data_ext    = sext(acc_t'(data_i), DATA_W);
        coef_ext    = sext(acc_t'(coef_i), COEF_W);
        product_ref = acc_t'($signed(data_ext) * $signed(coef_ext));
    end

    always_comb begin
        if (!$isunknown({data_i, coef_i})) begin
            // R1: the chain result is the signed product
            a_r1_product_matches: assert (product_o == product_ref)
                else $error("product %h != %h", product_o, product_ref);
            // R6: the last stage subtracts the sign-bit term
            a_r6_sign_subtract: assert (partial[COEF_W] == partial[LAST] - term[LAST])
                else $error("sign-bit term not subtracted");
        end
    end

endmodule

// File: tb/sam_mult_tb.sv
module sam_mult_tb;

    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic [DW-1:0] data;
    logic [CW-1:0] coef;
    logic [39:0]   product;
    int            total = 0;
    int            bad   = 0;
    bit            done  = 1'b0;

    always #5 clk = ~clk;

    sam_mult #(.DATA_W(DW), .COEF_W(CW)) u_dut (
        .data_i   (data),
        .coef_i   (coef),
        .product_o(product)
    );

    function automatic logic [39:0] expect_prod(input logic [DW-1:0] d, input logic [CW-1:0] c);
        longint e;
        e = longint'($signed(d)) * longint'($signed(c));
        return e[39:0];
    endfunction

    // Drive away from the rising edge, let the logic settle, then compare.
    task automatic apply_check(input string tag, input logic [DW-1:0] d, input logic [CW-1:0] c);
        logic [39:0] ex;
        @(negedge clk);
        data = d;
        coef = c;
        #1;
        ex = expect_prod(d, c);
        total++;
        if (product !== ex) begin
            bad++;
            $display("FAIL %s data=%h coef=%h got=%h expected=%h", tag, d, c, product, ex);
        end
    endtask

    task automatic t_idle_state;
        apply_check("R1 idle zero inputs", 16'h0000, 16'h0000);
    endtask

    task automatic t_zero;
        apply_check("R5 zero coefficient", 16'h7ABC, 16'h0000);
        apply_check("R5 zero sample", 16'h0000, 16'h8001);
        apply_check("R5 zero sample neg coef", 16'h0000, 16'hFFFF);
    endtask

    task automatic t_minus_one;
        apply_check("R6 coef -1", 16'h1234, 16'hFFFF);
        apply_check("R4 data -1", 16'hFFFF, 16'h1234);
        apply_check("R6 -1 times -1", 16'hFFFF, 16'hFFFF);
        apply_check("R6 coef -1 neg data", 16'h8000, 16'hFFFF);
    endtask

    task automatic t_extremes;
        apply_check("R6 min times min", 16'h8000, 16'h8000);
        apply_check("R6 min times max", 16'h8000, 16'h7FFF);
        apply_check("R1 max times max", 16'h7FFF, 16'h7FFF);
        apply_check("R6 max times min coef", 16'h7FFF, 16'h8000);
    endtask

    task automatic t_single_bits;
        for (int k = 0; k < CW - 1; k++) begin
            apply_check("R2 R3 single coef bit pos data", 16'h5A3C, 16'(1 << k));
            apply_check("R4 R5 single coef bit neg data", 16'hA5C3, 16'(1 << k));
        end
    endtask

    task automatic t_upper_bits;
        // Products reaching past bit 31 must keep bits 32..39 as sign copies.
        apply_check("R7 upper sign bits neg", 16'h8001, 16'h7FFF);
        apply_check("R7 upper sign bits pos", 16'h8001, 16'h8001);
        apply_check("R7 carry across all bits", 16'hFFFF, 16'h0001);
    endtask

    task automatic t_random;
        for (int n = 0; n < 400; n++) begin
            apply_check("R1 random operands", 16'($urandom), 16'($urandom));
        end
    endtask

    task automatic t_combinational;
        logic [39:0] ex;
        // Two input changes inside one low phase, no rising edge in between.
        @(negedge clk);
        data = 16'h0123;
        coef = 16'hF00D;
        #1;
        ex = expect_prod(16'h0123, 16'hF00D);
        total++;
        if (product !== ex) begin
            bad++;
            $display("FAIL R8 first change got=%h expected=%h", product, ex);
        end
        data = 16'hC0DE;
        coef = 16'h0042;
        #1;
        ex = expect_prod(16'hC0DE, 16'h0042);
        total++;
        if (product !== ex) begin
            bad++;
            $display("FAIL R8 second change got=%h expected=%h", product, ex);
        end
    endtask

    initial begin
        data = '0;
        coef = '0;
        t_idle_state();
        t_zero();
        t_minus_one();
        t_extremes();
        t_single_bits();
        t_upper_bits();
        t_random();
        t_combinational();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule